// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block runs the digital side of a three-phase dual-slope integrating converter. A prescaler divides the oscillator clock into a count enable. The block then steps an analog front end through three phases: auto-zero, signal integrate and reference de-integrate. It chooses the reference polarity from the comparator, counts the de-integration time in four BCD decades, and latches the reading together with its sign. The integrator, buffer, reference and display decoding sit outside the block. The comparator reaches it as a single digital input.

Every conversion has the same length in counts, whatever the input. The signal integrate window is fixed. De-integration stops on the first count at which the comparator flips, and auto-zero fills whatever time is left. When no flip arrives within full scale, the block latches an overrange code. The reading is presented on `digits_o` with one nibble per decade, units in bits [3:0], and is held between strobes.

Top module: `dsadc_sequencer`

## Requirements
- R1: `cnt_en_o` is high for exactly one oscillator cycle in every `DIV` cycles (default 4). Every count of the sequencer advances only on such a cycle.
- R2: The phases run in the fixed order auto-zero, signal integrate, reference integrate, auto-zero. Exactly one of `az_o`, `si_o`, `ri_o` is high at all times, and a phase changes only on a count.
- R3: Signal integrate lasts exactly `SI_CNT` counts (default 1000).
- R4: From the start of one signal integrate to the start of the next is always `CYCLE_CNT` counts (default 4000), which is `CYCLE_CNT*DIV` oscillator cycles.
- R5: Reference integrate ends on the first count at which `cmp_i` differs from the polarity sample. The latched reading is the number of earlier counts in that phase, so a phase of k+1 counts reads k. It is encoded in BCD, digit i in bits [4i+3:4i].
- R6: `cmp_i` (high means a negative input) is sampled on the last count of signal integrate. That sample drives `ref_neg_o` throughout reference integrate and becomes `sign_o` at the latch.
- R7: If `REF_MAX` counts (default 2000) pass in reference integrate without a flip, the block sets `over_o`, latches digit 3 as 1 and the lower digits as 4'hF (blank), and returns to auto-zero. A flip on the last count takes priority and reads `REF_MAX`-1.
- R8: Auto-zero lasts `CYCLE_CNT` minus the signal and reference phase lengths of the previous conversion. This gives 1000 to 2999 counts by default.
- R9: `strobe_o` pulses for one oscillator cycle, in the first cycle after reference integrate ends. `digits_o`, `sign_o` and `over_o` change only together with that pulse.
- R10: `cmp_i` has no effect during auto-zero or during the signal integrate counts before the last one.
- R11: While reset is asserted, the block sits in auto-zero with `digits_o`, `sign_o`, `over_o`, `strobe_o` and `cnt_en_o` at 0. The first auto-zero after reset lasts `CYCLE_CNT-SI_CNT-REF_MAX` counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmp_i | input | 1 | Integrator zero-crossing comparator, high for negative side |
| cnt_en_o | output | 1 | Count enable, one cycle in every DIV |
| az_o | output | 1 | Auto-zero switch control |
| si_o | output | 1 | Signal-integrate switch control |
| ri_o | output | 1 | Reference-integrate switch control |
| ref_neg_o | output | 1 | Reference polarity select for de-integration |
| strobe_o | output | 1 | One-cycle pulse when a new reading is latched |
| digits_o | output | 4*NDIG | Latched BCD reading, units in the low nibble |
| sign_o | output | 1 | Latched sign, high for negative input |
| over_o | output | 1 | Latched overrange flag |

## Verification
A wrong position counter or phase state shows up at the ports as a switch control whose duration is off by whole counts. The bench measures each phase length in counts, so the error is caught at the end of the phase in which it occurs. A wrong BCD carry or polarity sample appears in `digits_o` or `sign_o` at the very next strobe, which is at most one conversion later. A reading or strobe that escapes at any other time is caught on the next count, because the held outputs are compared on every count.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [1:0] {
    PH_AZ = 2'd0,
    PH_SI = 2'd1,
    PH_RI = 2'd2
  } phase_e;
endpackage

// File: rtl/dsadc_rst_sync.sv
module dsadc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/dsadc_prescale.sv
module dsadc_prescale #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_q, div_d;

  assign tick_o = (div_q == DW'(DIV - 1));

  always_comb begin
    div_d = tick_o ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

  // R1
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/dsadc_bcd_count.sv
module dsadc_bcd_count #(
  parameter int NDIG = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [4*NDIG-1:0] val_o
);
  logic [NDIG:0] carry;
  assign carry[0] = inc_i;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [3:0] dig_q, dig_d;

    assign carry[i+1] = carry[i] && (dig_q == 4'd9);

    always_comb begin
      dig_d = dig_q;
      if (clr_i)         dig_d = 4'd0;
      else if (carry[i]) dig_d = (dig_q == 4'd9) ? 4'd0 : dig_q + 4'd1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dig_q <= 4'd0;
      else         dig_q <= dig_d;
    end

    assign val_o[4*i +: 4] = dig_q;

    // R5
    digit_decimal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dig_q <= 4'd9);
  end
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int SI_CNT    = 1000,
  parameter int REF_MAX   = 2000,
  parameter int CYCLE_CNT = 4000,
  parameter int NDIG      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cmp_i,
  input  logic [4*NDIG-1:0] bcd_i,
  output logic              bcd_clr_o,
  output logic              bcd_inc_o,
  output logic              az_o,
  output logic              si_o,
  output logic              ri_o,
  output logic              ref_neg_o,
  output logic              strobe_o,
  output logic [4*NDIG-1:0] res_o,
  output logic              sign_o,
  output logic              over_o
);
  localparam int PW = $clog2(CYCLE_CNT + 1);
  localparam int RW = 4 * NDIG;
  localparam logic [PW-1:0] POS_LAST    = PW'(CYCLE_CNT - 1);
  localparam logic [PW-1:0] POS_SI_LAST = PW'(SI_CNT - 1);
  localparam logic [PW-1:0] POS_RI_LAST = PW'(SI_CNT + REF_MAX - 1);
  localparam logic [PW-1:0] POS_RESET   = PW'(SI_CNT + REF_MAX);
  localparam logic [RW-1:0] OVR_PAT     = {4'd1, {(NDIG-1){4'hF}}};

  phase_e        state_q, state_d;
  logic [PW-1:0] pos_q, pos_d;
  logic          pol_q, pol_d;
  logic [RW-1:0] res_q, res_d;
  logic          sgn_q, sgn_d;
  logic          ovr_q, ovr_d;
  logic          stb_q, stb_d;
  logic          latch, ovr_hit;

  always_comb begin
    state_d   = state_q;
    pos_d     = pos_q;
    pol_d     = pol_q;
    latch     = 1'b0;
    ovr_hit   = 1'b0;
    bcd_clr_o = 1'b0;
    bcd_inc_o = 1'b0;
    if (tick_i) begin
      pos_d = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
      unique case (state_q)
        PH_AZ: begin
          if (pos_q == POS_LAST) state_d = PH_SI;
        end
        PH_SI: begin
          if (pos_q == POS_SI_LAST) begin
            state_d   = PH_RI;
            pol_d     = cmp_i;
            bcd_clr_o = 1'b1;
          end
        end
        PH_RI: begin
          if (cmp_i != pol_q) begin
            latch   = 1'b1;
            state_d = PH_AZ;
          end else begin
            bcd_inc_o = 1'b1;
            if (pos_q == POS_RI_LAST) begin
              latch   = 1'b1;
              ovr_hit = 1'b1;
              state_d = PH_AZ;
            end
          end
        end
        default: state_d = PH_AZ;
      endcase
    end
  end

  always_comb begin
    res_d = res_q;
    sgn_d = sgn_q;
    ovr_d = ovr_q;
    stb_d = latch;
    if (latch) begin
      res_d = ovr_hit ? OVR_PAT : bcd_i;
      sgn_d = pol_q;
      ovr_d = ovr_hit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_AZ;
      pos_q   <= POS_RESET;
      pol_q   <= 1'b0;
      res_q   <= '0;
      sgn_q   <= 1'b0;
      ovr_q   <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      pol_q   <= pol_d;
      res_q   <= res_d;
      sgn_q   <= sgn_d;
      ovr_q   <= ovr_d;
      stb_q   <= stb_d;
    end
  end

  assign az_o      = (state_q == PH_AZ);
  assign si_o      = (state_q == PH_SI);
  assign ri_o      = (state_q == PH_RI);
  assign ref_neg_o = pol_q;
  assign strobe_o  = stb_q;
  assign res_o     = res_q;
  assign sign_o    = sgn_q;
  assign over_o    = ovr_q;

  // R2
  phase_on_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(state_q) |-> $past(tick_i));

  // R9
  strobe_after_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> (state_q == PH_AZ && $past(state_q) == PH_RI));

  // R6
  polarity_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_RI && $past(state_q) == PH_RI) |-> $stable(pol_q));

  // R7
  over_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |-> (res_q[RW-1 -: 4] == 4'd1));
endmodule

// File: rtl/dsadc_sequencer.sv
module dsadc_sequencer #(
  parameter int DIV       = 4,
  parameter int SI_CNT    = 1000,
  parameter int REF_MAX   = 2000,
  parameter int CYCLE_CNT = 4000,
  parameter int NDIG      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_i,
  output logic              cnt_en_o,
  output logic              az_o,
  output logic              si_o,
  output logic              ri_o,
  output logic              ref_neg_o,
  output logic              strobe_o,
  output logic [4*NDIG-1:0] digits_o,
  output logic              sign_o,
  output logic              over_o
);
  localparam int RW = 4 * NDIG;

  logic          rst_n;
  logic          tick;
  logic          bcd_clr, bcd_inc;
  logic [RW-1:0] bcd_val;

  dsadc_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  dsadc_prescale #(.DIV(DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .tick_o (tick)
  );

  dsadc_bcd_count #(.NDIG(NDIG)) u_bcd (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .clr_i  (bcd_clr),
    .inc_i  (bcd_inc),
    .val_o  (bcd_val)
  );

  dsadc_seq #(
    .SI_CNT    (SI_CNT),
    .REF_MAX   (REF_MAX),
    .CYCLE_CNT (CYCLE_CNT),
    .NDIG      (NDIG)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .cmp_i     (cmp_i),
    .bcd_i     (bcd_val),
    .bcd_clr_o (bcd_clr),
    .bcd_inc_o (bcd_inc),
    .az_o      (az_o),
    .si_o      (si_o),
    .ri_o      (ri_o),
    .ref_neg_o (ref_neg_o),
    .strobe_o  (strobe_o),
    .res_o     (digits_o),
    .sign_o    (sign_o),
    .over_o    (over_o)
  );

  assign cnt_en_o = tick;

  // R2
  one_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $countones({az_o, si_o, ri_o}) == 1);

  // R9
  result_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !strobe_o |-> ($stable(digits_o) && $stable(sign_o) && $stable(over_o)));
endmodule

// File: tb/dsadc_sequencer_tb_top.sv
module dsadc_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int SI_CNT     = 10;
  localparam int REF_MAX    = 20;
  localparam int CYCLE_CNT  = 40;
  localparam int NDIG       = 4;
  localparam int RW         = 4 * NDIG;
  localparam int WD_CYCLES  = 150000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmp;
  logic          cnt_en_o, az_o, si_o, ri_o, ref_neg_o, strobe_o, sign_o, over_o;
  logic [RW-1:0] digits_o;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;
  int ncyc = 0;

  logic [RW-1:0] last_dig;
  logic          last_sgn, last_ovr;
  int            az_exp;
  int            si_start;
  bit            have_start;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) ncyc <= ncyc + 1;

  dsadc_sequencer #(
    .DIV(DIV), .SI_CNT(SI_CNT), .REF_MAX(REF_MAX),
    .CYCLE_CNT(CYCLE_CNT), .NDIG(NDIG)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp), .cnt_en_o(cnt_en_o),
    .az_o(az_o), .si_o(si_o), .ri_o(ri_o), .ref_neg_o(ref_neg_o),
    .strobe_o(strobe_o), .digits_o(digits_o), .sign_o(sign_o), .over_o(over_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] to_bcd(input int v);
    logic [RW-1:0] r;
    int x = v;
    for (int i = 0; i < NDIG; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  function automatic logic [RW-1:0] over_code();
    logic [RW-1:0] r = '1;
    r[RW-1 -: 4] = 4'd1;
    return r;
  endfunction

  task automatic hold_chk();
    chk("R9 strobe idle", strobe_o, 0);
    chk("R9 digits held", digits_o, last_dig);
    chk("R9 sign held", sign_o, last_sgn);
    chk("R9 over held", over_o, last_ovr);
  endtask

  // One conversion: s = sign to present, k = count index at which cmp flips
  task automatic run_conv(input bit s, input int k);
    int az_t = 0;
    int si_t = 0;
    int ri_t = 0;
    int exp_ri;
    // R10: comparator toggles freely during auto-zero
    while (az_o) begin
      if (cnt_en_o) begin
        az_t++;
        hold_chk();
        cmp = 1'($urandom);
      end
      @(negedge clk);
    end
    chk("R8 auto-zero length", az_t, az_exp);
    chk("R2 signal follows auto-zero", si_o, 1);
    if (have_start) chk("R4 cycle length", ncyc - si_start, CYCLE_CNT * DIV);
    si_start = ncyc;
    have_start = 1'b1;
    while (si_o) begin
      if (cnt_en_o) begin
        hold_chk();
        // R10: only the last signal count samples cmp
        cmp = (si_t == SI_CNT - 1) ? s : 1'($urandom);
        si_t++;
      end
      @(negedge clk);
    end
    chk("R3 signal length", si_t, SI_CNT);
    chk("R2 reference follows signal", ri_o, 1);
    while (ri_o) begin
      if (cnt_en_o) begin
        chk("R6 ref polarity", ref_neg_o, s);
        hold_chk();
        if (ri_t == k) cmp = ~s;
        ri_t++;
      end
      @(negedge clk);
    end
    exp_ri = (k < REF_MAX) ? k + 1 : REF_MAX;
    chk("R5 reference length", ri_t, exp_ri);
    chk("R2 auto-zero follows reference", az_o, 1);
    chk("R9 strobe pulse", strobe_o, 1);
    if (k < REF_MAX) begin
      chk("R5 reading", digits_o, to_bcd(k));
      chk("R7 no overrange", over_o, 0);
    end else begin
      chk("R7 overrange code", digits_o, over_code());
      chk("R7 overrange flag", over_o, 1);
    end
    chk("R6 sign", sign_o, s);
    last_dig = digits_o;
    last_sgn = sign_o;
    last_ovr = over_o;
    az_exp = CYCLE_CNT - SI_CNT - ri_t;
    @(negedge clk);
    chk("R9 strobe single cycle", strobe_o, 0);
  endtask

  // R1 monitor: count enable spacing
  initial begin
    int gap = -1;
    @(posedge rst_n);
    while (!done) begin
      @(negedge clk);
      if (gap >= 0) gap++;
      if (cnt_en_o) begin
        if (gap >= 0) chk("R1 count enable spacing", gap, DIV);
        gap = 0;
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0D51_5EED));
    rst_n = 1'b0;
    cmp   = 1'b0;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11 az in reset", az_o, 1);
    chk("R11 si in reset", si_o, 0);
    chk("R11 ri in reset", ri_o, 0);
    chk("R11 strobe in reset", strobe_o, 0);
    chk("R11 digits in reset", digits_o, 0);
    chk("R11 sign in reset", sign_o, 0);
    chk("R11 over in reset", over_o, 0);
    chk("R11 cnt_en in reset", cnt_en_o, 0);
    last_dig = '0;
    last_sgn = 1'b0;
    last_ovr = 1'b0;
    az_exp = CYCLE_CNT - SI_CNT - REF_MAX;  // R11 first auto-zero
    have_start = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run_conv(1'b0, 0);
    run_conv(1'b1, 0);
    run_conv(1'b0, REF_MAX - 1);
    run_conv(1'b1, REF_MAX - 1);
    run_conv(1'b0, REF_MAX);
    run_conv(1'b1, REF_MAX + 3);
    run_conv(1'b1, 9);
    run_conv(1'b0, 10);
    // constrained random
    for (int n = 0; n < 50; n++) begin
      run_conv(1'($urandom), int'($urandom % (REF_MAX + 4)));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule